// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting channel of an interval timer. A single-cycle count enable (`tick`) advances it, and a gate input either holds counting or restarts it, depending on the mode. A one-cycle `load` strobe takes a reload value and a 3-bit mode at the same time and starts counting from the new value. The channel drives a live count and one output pin. A bus-side block reads both, and that block also owns register access, latching and BCD.

Six modes are supported: interrupt on terminal count (0), retriggerable one-shot (1), rate generator (2), square wave (3), software strobe (4) and gate-triggered strobe (5). A reload of zero stands for a period of 65536 ticks. The channel has no stream data path, so every pin is a plain control or status signal with no handshake and no back-pressure.

Top module: `ictr_channel`

## Requirements
- R1: After reset the count reads 0, the output is high and the channel is unprogrammed: `tick` and `gate` change neither the count nor the output until a load.
- R2: A `load` pulse makes `count_o` equal `load_val` on the next cycle and captures `mode_in`, and it takes priority over `tick` and gate edges in that cycle; mode codes 6 and 7 leave the channel unprogrammed, holding the loaded value with the output high.
- R3: A reload of 0 behaves as 65536: in mode 0 the output rises after exactly 65536 ticks, and in modes 2 and 3 the first tick takes the count from 0 to 0xFFFF and 0xFFFE.
- R4: Mode 0: the output goes low on load, the count falls by one per tick, the output rises on the tick that brings the count to 0 and stays high while the count wraps, until the next load.
- R5: In modes 0, 2, 3 and 4 the count and output are frozen while `gate` is low; in modes 1 and 5 counting goes on with `gate` low.
- R6: Mode 2 with reload N ≥ 2: the count runs N, N-1, …, 1 and then reloads N, one value per tick; the output is low exactly while the count is 1.
- R7: Mode 3 with reload N ≥ 2: the count falls by 2 per tick; the output is high for ceil(N/2) ticks starting at N and low for floor(N/2) ticks starting at N rounded down to even, then it repeats.
- R8: Mode 1: the output goes low on load and rises on the tick that brings the count to 0, and it stays high after that.
- R9: Modes 4 and 5: the output is high after a load and goes low for one tick when the count first reaches 0 after that load or trigger; the count keeps wrapping and later passes through 0 give no further pulse.
- R10: A gate rising edge (gate high in a cycle after a cycle where it was low) reloads the count in modes 1, 2, 3 and 5, with no tick needed. It also drives the output low in mode 1, sets it high in mode 3 and re-arms the strobe in mode 5. In modes 0 and 4 a gate rising edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one counting step per cycle it is high |
| load | input | 1 | Strobe: take `load_val` and `mode_in` |
| load_val | input | 16 | Reload value, 0 means 65536 |
| mode_in | input | 3 | Mode code 0..5; 6 and 7 leave the channel unprogrammed |
| gate | input | 1 | Gate level: pauses or retriggers, per mode |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Channel output pin |

## Verification
A table of vectors sets each mode with odd and even reloads and with the gate held high or low, then applies a chosen number of ticks. These vectors separate the one-step modes from the two-step square wave, separate reload-at-1 from wrap-through-0, and show which modes the gate can pause. Directed sequences then apply gate rising edges between ticks in every mode to tell retriggering modes from the ones that ignore the edge. Long runs check a zero reload, the 65536-tick count, and that the strobe fires only once per load.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    M_TCINT  = 3'd0,
    M_ONESHT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTRB = 3'd4,
    M_HWSTRB = 3'd5,
    M_IDLE   = 3'd7
  } mode_e;

  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd0: return M_TCINT;
      3'd1: return M_ONESHT;
      3'd2: return M_RATE;
      3'd3: return M_SQUARE;
      3'd4: return M_SWSTRB;
      3'd5: return M_HWSTRB;
      default: return M_IDLE;
    endcase
  endfunction

  function automatic logic gate_pauses(input mode_e m);
    return (m == M_TCINT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTRB);
  endfunction

  function automatic logic gate_retrigs(input mode_e m);
    return (m == M_ONESHT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTRB);
  endfunction
endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/ictr_step.sv
module ictr_step
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_e          mode,
  input  logic [W-1:0]   cnt,
  input  logic [W-1:0]   reload,
  input  logic           out_q,
  input  logic           armed,
  input  logic           load,
  input  logic [W-1:0]   load_val,
  input  logic [2:0]     mode_in,
  input  logic           rise,
  input  logic           tick,
  input  logic           gate,
  output logic [W-1:0]   nxt_cnt,
  output logic           nxt_out,
  output logic           nxt_armed
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);
  localparam logic [W-1:0] EVEN_MASK = ~ONE;

  mode_e new_mode;
  logic  run;
  logic  at_one;

  assign new_mode = decode_mode(mode_in);
  assign run      = tick && (mode != M_IDLE) && (gate || !gate_pauses(mode));
  assign at_one   = (cnt == ONE);

  always_comb begin
    nxt_cnt   = cnt;
    nxt_out   = out_q;
    nxt_armed = armed;
    if (load) begin
      nxt_cnt   = load_val;
      nxt_out   = !((new_mode == M_TCINT) || (new_mode == M_ONESHT));
      nxt_armed = 1'b1;
    end else if (rise && gate_retrigs(mode)) begin
      nxt_cnt = reload;
      case (mode)
        M_ONESHT: nxt_out = 1'b0;
        M_SQUARE: nxt_out = 1'b1;
        M_HWSTRB: begin
          nxt_out   = 1'b1;
          nxt_armed = 1'b1;
        end
        default: ;
      endcase
    end else if (run) begin
      case (mode)
        M_TCINT, M_ONESHT: begin
          nxt_cnt = cnt - ONE;
          if (at_one) nxt_out = 1'b1;
        end
        M_RATE: begin
          nxt_cnt = at_one ? reload : cnt - ONE;
        end
        M_SQUARE: begin
          if (at_one || cnt == TWO) begin
            nxt_out = ~out_q;
            nxt_cnt = out_q ? (reload & EVEN_MASK) : reload;
          end else begin
            nxt_cnt = cnt - TWO;
          end
        end
        M_SWSTRB, M_HWSTRB: begin
          nxt_cnt = cnt - ONE;
          if (!out_q) begin
            nxt_out = 1'b1;
          end else if (armed && at_one) begin
            nxt_out   = 1'b0;
            nxt_armed = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode_in,
  input  logic         gate,
  output logic [W-1:0] count_o,
  output logic         out_o
);
  mode_e          mode_q;
  logic [W-1:0]   cnt_q, reload_q, nxt_cnt;
  logic           out_q, armed_q, nxt_out, nxt_armed;
  logic           rise;

  ictr_gate_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .rise (rise)
  );

  ictr_step #(.W(W)) u_step (
    .mode     (mode_q),
    .cnt      (cnt_q),
    .reload   (reload_q),
    .out_q    (out_q),
    .armed    (armed_q),
    .load     (load),
    .load_val (load_val),
    .mode_in  (mode_in),
    .rise     (rise),
    .tick     (tick),
    .gate     (gate),
    .nxt_cnt  (nxt_cnt),
    .nxt_out  (nxt_out),
    .nxt_armed(nxt_armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b1;
      armed_q  <= 1'b0;
    end else begin
      if (load) begin
        mode_q   <= decode_mode(mode_in);
        reload_q <= load_val;
      end
      cnt_q   <= nxt_cnt;
      out_q   <= nxt_out;
      armed_q <= nxt_armed;
    end
  end

  assign count_o = cnt_q;
  assign out_o   = (mode_q == M_RATE) ? (cnt_q != W'(1)) : out_q;
endmodule

// File: rtl/ictr_channel_chk.sv
module ictr_channel_chk
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic         gate,
  input mode_e        mode_q,
  input logic [W-1:0] count_o,
  input logic         out_o
);
  // R2: a load shows its value one cycle later
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_o == $past(load_val)));

  // R1: unprogrammed channel holds its count, output high
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !load) |=> ($stable(count_o) && out_o));

  // R5: gate low freezes the count in the pausing modes
  p_gate_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !gate && gate_pauses(mode_q)) |=> $stable(count_o));

  // R4: once high in mode 0, the output stays high until a load
  p_m0_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TCINT && out_o && !load) |=> out_o);

  // R6: the low pulse of the rate generator lasts one tick
  p_m2_one_tick_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_o && tick && gate && !load) |=> out_o);

  // R7: square wave count falls by two away from the phase boundary
  p_m3_step_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && tick && gate && $past(gate) && !load &&
     (count_o > W'(2) || count_o == '0))
    |=> (count_o == $past(count_o) - W'(2)));
endmodule

bind ictr_channel ictr_channel_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .load    (load),
  .load_val(load_val),
  .gate    (gate),
  .mode_q  (mode_q),
  .count_o (count_o),
  .out_o   (out_o)
);

// File: tb/sim_ictr_channel.sv
module sim_ictr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_in = '0;
  logic        gate = 1'b0;
  logic [15:0] count_o;
  logic        out_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ictr_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(load_val), .mode_in(mode_in), .gate(gate),
    .count_o(count_o), .out_o(out_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;
    logic [15:0] val;
    logic        g;
    logic [7:0]  n;
    logic [15:0] ecnt;
    logic        eout;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd4,  3'd0, 16'd10, 1'b1, 8'd3,  16'd7,      1'b0}, // R4
    '{4'd4,  3'd0, 16'd10, 1'b1, 8'd10, 16'd0,      1'b1}, // R4
    '{4'd4,  3'd0, 16'd10, 1'b1, 8'd12, 16'hFFFE,   1'b1}, // R4
    '{4'd5,  3'd0, 16'd10, 1'b0, 8'd5,  16'd10,     1'b0}, // R5
    '{4'd5,  3'd1, 16'd10, 1'b0, 8'd4,  16'd6,      1'b0}, // R5
    '{4'd8,  3'd1, 16'd5,  1'b0, 8'd5,  16'd0,      1'b1}, // R8
    '{4'd6,  3'd2, 16'd5,  1'b1, 8'd4,  16'd1,      1'b0}, // R6
    '{4'd6,  3'd2, 16'd5,  1'b1, 8'd5,  16'd5,      1'b1}, // R6
    '{4'd6,  3'd2, 16'd5,  1'b1, 8'd7,  16'd3,      1'b1}, // R6
    '{4'd5,  3'd2, 16'd5,  1'b0, 8'd3,  16'd5,      1'b1}, // R5
    '{4'd7,  3'd3, 16'd6,  1'b1, 8'd2,  16'd2,      1'b1}, // R7
    '{4'd7,  3'd3, 16'd6,  1'b1, 8'd3,  16'd6,      1'b0}, // R7
    '{4'd7,  3'd3, 16'd6,  1'b1, 8'd6,  16'd6,      1'b1}, // R7
    '{4'd7,  3'd3, 16'd7,  1'b1, 8'd3,  16'd1,      1'b1}, // R7
    '{4'd7,  3'd3, 16'd7,  1'b1, 8'd4,  16'd6,      1'b0}, // R7
    '{4'd7,  3'd3, 16'd7,  1'b1, 8'd6,  16'd2,      1'b0}, // R7
    '{4'd7,  3'd3, 16'd7,  1'b1, 8'd7,  16'd7,      1'b1}, // R7
    '{4'd9,  3'd4, 16'd3,  1'b1, 8'd2,  16'd1,      1'b1}, // R9
    '{4'd9,  3'd4, 16'd3,  1'b1, 8'd3,  16'd0,      1'b0}, // R9
    '{4'd9,  3'd4, 16'd3,  1'b1, 8'd4,  16'hFFFF,   1'b1}, // R9
    '{4'd9,  3'd5, 16'd3,  1'b0, 8'd3,  16'd0,      1'b0}, // R9
    '{4'd9,  3'd4, 16'd3,  1'b1, 8'd5,  16'hFFFE,   1'b1}, // R9
    '{4'd3,  3'd3, 16'd0,  1'b1, 8'd1,  16'hFFFE,   1'b1}, // R3
    '{4'd3,  3'd2, 16'd0,  1'b1, 8'd1,  16'hFFFF,   1'b1}, // R3
    '{4'd2,  3'd6, 16'd9,  1'b1, 8'd4,  16'd9,      1'b1}  // R2
  };

  task automatic check(input string tag, input logic [15:0] ec, input logic eo);
    checks++;
    if (count_o !== ec || out_o !== eo) begin
      errors++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               tag, count_o, out_o, ec, eo);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    @(negedge clk);
    load = 1'b1; mode_in = m; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk);
    gate = g;
  endtask

  task automatic gate_pulse;
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: count=%h out=%b expected completion", count_o, out_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 16'd0, 1'b1);
    gate = 1'b1;
    run_ticks(5);
    check("R1 unprogrammed ignores tick and gate", 16'd0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      set_gate(VECS[i].g);
      do_load(VECS[i].mode, VECS[i].val);
      run_ticks(int'(VECS[i].n));
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ecnt, VECS[i].eout);
    end

    // R2: load wins over a tick in the same cycle
    set_gate(1'b1);
    @(negedge clk);
    tick = 1'b1; load = 1'b1; mode_in = 3'd0; load_val = 16'd20;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    check("R2 load priority over tick", 16'd20, 1'b0);

    // R10: mode 0 ignores a gate rising edge
    do_load(3'd0, 16'd10);
    run_ticks(3);
    gate_pulse();
    check("R10 mode 0 gate edge ignored", 16'd7, 1'b0);

    // R10: mode 2 reloads on a gate rising edge
    do_load(3'd2, 16'd5);
    run_ticks(2);
    gate_pulse();
    check("R10 mode 2 retrigger", 16'd5, 1'b1);

    // R10: mode 3 reloads into the high half
    do_load(3'd3, 16'd6);
    run_ticks(3);
    check("R7 mode 3 low half", 16'd6, 1'b0);
    gate_pulse();
    check("R10 mode 3 retrigger", 16'd6, 1'b1);

    // R8 and R10: mode 1 retrigger mid-count and after terminal count
    set_gate(1'b0);
    do_load(3'd1, 16'd10);
    run_ticks(4);
    set_gate(1'b1);
    @(negedge clk);
    check("R8 mode 1 retrigger mid count", 16'd10, 1'b0);
    run_ticks(10);
    check("R8 mode 1 terminal count", 16'd0, 1'b1);
    gate_pulse();
    check("R8 mode 1 retrigger after terminal", 16'd10, 1'b0);

    // R9 and R10: mode 5 strobe re-armed by a gate edge
    do_load(3'd5, 16'd3);
    run_ticks(3);
    check("R9 mode 5 strobe", 16'd0, 1'b0);
    run_ticks(1);
    check("R9 mode 5 strobe ends", 16'hFFFF, 1'b1);
    gate_pulse();
    check("R10 mode 5 retrigger", 16'd3, 1'b1);
    run_ticks(3);
    check("R9 mode 5 strobe re-armed", 16'd0, 1'b0);

    // R10: mode 4 ignores a gate rising edge
    do_load(3'd4, 16'd8);
    run_ticks(2);
    gate_pulse();
    check("R10 mode 4 gate edge ignored", 16'd6, 1'b1);

    // R9: one pulse per load, even after a full wrap
    do_load(3'd4, 16'd2);
    run_ticks(2);
    check("R9 mode 4 first pulse", 16'd0, 1'b0);
    run_ticks(65536);
    check("R9 mode 4 no second pulse", 16'd0, 1'b1);

    // R3: zero reload in mode 0 takes 65536 ticks
    do_load(3'd0, 16'd0);
    run_ticks(65535);
    check("R3 zero reload one tick short", 16'd1, 1'b0);
    run_ticks(1);
    check("R3 zero reload terminal", 16'd0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule